// File: doc/BRIEF.md
# Virtqueue Common Configuration Register Window

This block is the memory-mapped window a driver uses to bring up a paravirtual device on a PCI function. A host access port delivers byte, word, dword and qword reads and writes at a 6-bit offset. Data is little-endian and right-justified on the data bus. Device-wide registers cover feature negotiation, the configuration interrupt vector, the queue count, the device status byte and the configuration generation. A queue selector points every per-queue register access at one of `NQ` queue banks. Each bank holds a ring size, an interrupt vector, an enable flag and three 64-bit ring base addresses.

The offered feature set enters as a 64-bit vector, and the driver reads it in two 32-bit pages. Feature acknowledgements leave as a one-cycle strobe that carries the written value already placed in its 64-bit page. Each queue's size, enable and ring addresses are driven out as flat buses for the queue engine.

A small response state machine has two states. `ST_IDLE` is the state with no response pending. `ST_RESP` is the state in which `rsp_valid` is high and `rsp_rdata` holds the data of the read from the previous cycle. The transition `IDLE->RESP` happens on a read request. `RESP->RESP` happens on a back-to-back read. `RESP->IDLE` happens on any cycle without a read.

Top module: `vq_common_regs`

## Requirements
- R1: After reset every register reads zero and every queue size reads `QSIZE_MAX` (256). `q_enable`, the ring outputs, `rsp_valid`, `rsp_rdata` and `feat_ack_valid` are all zero.
- R2: A read request (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 in the next cycle, with the value in `rsp_rdata`, right-justified and zero-extended. `rsp_valid` is never high unless the previous cycle carried a read request.
- R3: The size code is 0=byte, 1=word, 2=dword, 3=qword. Byte accesses decode only 0x14 (status) and 0x15 (generation). Word accesses decode 0x10..0x1E. Dword accesses decode 0x00, 0x04, 0x08, 0x0C and the ring halves 0x20..0x34. The same offset at another width is undefined (for example, a word read at 0x14 returns 0).
- R4: A dword read at 0x04 returns `dev_features[31:0]` when the device-feature page select (dword 0x00) is 0. It returns `dev_features[63:32]` when the select is 1, and 0 when the select is 2 or more.
- R5: A dword write at 0x0C pulses `feat_ack_valid` for one cycle in the cycle after the write. `feat_ack_data` then carries the value shifted left by 32 times the driver page select (dword 0x08). If that select is 2 or more, no pulse occurs.
- R6: The generation byte (0x15, always 0), the feature page (0x04), the queue count (0x12) and the notify offset (0x1E) ignore writes. The status byte (0x14) stores all 8 bits.
- R7: A word read at 0x12 returns `NQ`. A word read at 0x1E returns the current queue select value (word 0x16).
- R8: A word write at 0x1C sets the selected queue's enable only when the value is exactly 1, and clears it for any other value. A read returns 1 or 0.
- R9: The ring bases are at 0x20 (descriptor), 0x28 (available) and 0x30 (used). Each can be written as a low dword (base) and a high dword (base+4), or as one qword at the base. The values appear on `q_desc`, `q_avail` and `q_used` at bits [64*q +: 64]. Dword reads of the ring offsets return 0.
- R10: Every qword read returns 0.
- R11: Reads at undefined offsets, or with size codes 4..7, return 0. Writes to them change nothing.
- R12: When the queue select is `NQ` or more, per-queue reads (0x18, 0x1A, 0x1C) return 0 and per-queue writes change no queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access width code (0 byte, 1 word, 2 dword, 3 qword) |
| req_offset | input | 6 | Byte offset in the window |
| req_wdata | input | 64 | Right-justified write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Registered read data |
| dev_features | input | 64 | Feature bits offered by the device |
| feat_ack_valid | output | 1 | Driver feature acknowledge strobe |
| feat_ack_data | output | 64 | Acknowledged bits placed in their page |
| q_size | output | 16*NQ | Ring size per queue |
| q_enable | output | NQ | Enable per queue |
| q_desc | output | 64*NQ | Descriptor ring base per queue |
| q_avail | output | 64*NQ | Available ring base per queue |
| q_used | output | 64*NQ | Used ring base per queue |

## Verification
The bench builds the block with `NQ` = 3 and `QSIZE_MAX` = 256. With three queues, a select value of 3 is already out of range, so both sides of the range check can be reached with small selects. With a maximum of 256, the reset size has bits above the low byte, which shows that word reads are not cut to a byte. Both feature pages are tested with a vector whose halves differ. Select values of 2 for both feature pages cover the paths that return zero or drop the acknowledge.

// File: rtl/vq_cfg_pkg.sv
package vq_cfg_pkg;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_WORD  = 3'd1,
        SZ_DWORD = 3'd2,
        SZ_QWORD = 3'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    localparam logic [5:0] OFF_DFSEL   = 6'h00;
    localparam logic [5:0] OFF_DFEAT   = 6'h04;
    localparam logic [5:0] OFF_DRFSEL  = 6'h08;
    localparam logic [5:0] OFF_DRFEAT  = 6'h0C;
    localparam logic [5:0] OFF_CFGVEC  = 6'h10;
    localparam logic [5:0] OFF_NUMQ    = 6'h12;
    localparam logic [5:0] OFF_STATUS  = 6'h14;
    localparam logic [5:0] OFF_GEN     = 6'h15;
    localparam logic [5:0] OFF_QSEL    = 6'h16;
    localparam logic [5:0] OFF_QSIZE   = 6'h18;
    localparam logic [5:0] OFF_QVEC    = 6'h1A;
    localparam logic [5:0] OFF_QEN     = 6'h1C;
    localparam logic [5:0] OFF_QNOTIFY = 6'h1E;
    localparam logic [5:0] OFF_RING0   = 6'h20;

    localparam int RING_COUNT = 3;

endpackage

// File: rtl/vq_feature_pager.sv
module vq_feature_pager #(
    parameter int SELW  = 32,
    parameter int PAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_dev_sel,
    input  logic            we_drv_sel,
    input  logic            we_ack,
    input  logic [31:0]     wdata,
    input  logic [63:0]     features,
    output logic [SELW-1:0] dev_sel,
    output logic [SELW-1:0] drv_sel,
    output logic [31:0]     page_out,
    output logic            ack_valid,
    output logic [63:0]     ack_data
);
    localparam logic [SELW-1:0] PAGE_LIM = SELW'(PAGES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_sel   <= '0;
            drv_sel   <= '0;
            ack_valid <= 1'b0;
            ack_data  <= '0;
        end else begin
            if (we_dev_sel) dev_sel <= wdata[SELW-1:0];
            if (we_drv_sel) drv_sel <= wdata[SELW-1:0];
            ack_valid <= we_ack && (drv_sel < PAGE_LIM);
            if (we_ack && (drv_sel < PAGE_LIM))
                ack_data <= drv_sel[0] ? {wdata, 32'h0} : {32'h0, wdata};
        end
    end

    always_comb begin
        if (dev_sel >= PAGE_LIM) page_out = '0;
        else if (dev_sel[0])     page_out = features[63:32];
        else                     page_out = features[31:0];
    end
endmodule

// File: rtl/vq_queue_bank.sv
module vq_queue_bank #(
    parameter int NQ        = 8,
    parameter int QSIZE_MAX = 256,
    parameter int QIW       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [QIW-1:0]   sel_idx,
    input  logic             sel_ok,
    input  logic             we_size,
    input  logic             we_vec,
    input  logic             we_en,
    input  logic [2:0]       ring_we,
    input  logic [1:0]       ring_mask,
    input  logic [63:0]      wdata,
    output logic [15:0]      rd_size,
    output logic [15:0]      rd_vec,
    output logic             rd_en,
    output logic [NQ*16-1:0] q_size_o,
    output logic [NQ-1:0]    q_en_o,
    output logic [NQ*64-1:0] q_desc_o,
    output logic [NQ*64-1:0] q_avail_o,
    output logic [NQ*64-1:0] q_used_o
);
    localparam logic [15:0] SIZE_RST = 16'(QSIZE_MAX);

    logic [15:0] size_a [NQ];
    logic [15:0] vec_a  [NQ];
    logic        en_a   [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic        hit;
        logic [15:0] size_r, vec_r;
        logic        en_r;
        logic [63:0] ring_r [3];

        assign hit = sel_ok && (sel_idx == QIW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_r <= SIZE_RST;
                vec_r  <= '0;
                en_r   <= 1'b0;
                for (int k = 0; k < 3; k++) ring_r[k] <= '0;
            end else if (hit) begin
                if (we_size) size_r <= wdata[15:0];
                if (we_vec)  vec_r  <= wdata[15:0];
                if (we_en)   en_r   <= (wdata[15:0] == 16'd1);
                for (int k = 0; k < 3; k++) begin
                    if (ring_we[k] && ring_mask[0]) ring_r[k][31:0]  <= wdata[31:0];
                    if (ring_we[k] && ring_mask[1]) ring_r[k][63:32] <= wdata[63:32];
                end
            end
        end

        assign size_a[g] = size_r;
        assign vec_a[g]  = vec_r;
        assign en_a[g]   = en_r;
        assign q_size_o[g*16 +: 16]  = size_r;
        assign q_en_o[g]             = en_r;
        assign q_desc_o[g*64 +: 64]  = ring_r[0];
        assign q_avail_o[g*64 +: 64] = ring_r[1];
        assign q_used_o[g*64 +: 64]  = ring_r[2];
    end

    always_comb begin
        rd_size = '0;
        rd_vec  = '0;
        rd_en   = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (sel_ok && sel_idx == QIW'(i)) begin
                rd_size = size_a[i];
                rd_vec  = vec_a[i];
                rd_en   = en_a[i];
            end
        end
    end
endmodule

// File: rtl/vq_common_regs.sv
module vq_common_regs #(
    parameter int NQ        = 8,
    parameter int QSIZE_MAX = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [2:0]       req_size,
    input  logic [5:0]       req_offset,
    input  logic [63:0]      req_wdata,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    input  logic [63:0]      dev_features,
    output logic             feat_ack_valid,
    output logic [63:0]      feat_ack_data,
    output logic [NQ*16-1:0] q_size,
    output logic [NQ-1:0]    q_enable,
    output logic [NQ*64-1:0] q_desc,
    output logic [NQ*64-1:0] q_avail,
    output logic [NQ*64-1:0] q_used
);
    import vq_cfg_pkg::*;

    localparam int          QIW    = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [15:0] NQ_VAL = 16'(NQ);

    rsp_state_e state_q, state_d;

    logic        wr, rd, is_b, is_w, is_d, is_q;
    logic [7:0]  status_q;
    logic [15:0] cfgvec_q, qsel_q;
    logic        sel_ok;
    logic [2:0]  ring_we;
    logic [1:0]  ring_mask;
    logic [63:0] ring_wdata, rd_mux;
    logic [31:0] dev_sel, drv_sel, feat_page;
    logic [15:0] b_size, b_vec;
    logic        b_en;

    assign wr   = req_valid &&  req_write;
    assign rd   = req_valid && !req_write;
    assign is_b = (req_size == SZ_BYTE);
    assign is_w = (req_size == SZ_WORD);
    assign is_d = (req_size == SZ_DWORD);
    assign is_q = (req_size == SZ_QWORD);

    assign sel_ok = (qsel_q < NQ_VAL);

    // ring address decode: dword halves or qword at the base
    for (genvar k = 0; k < RING_COUNT; k++) begin : g_ring
        localparam logic [5:0] BASE = OFF_RING0 + 6'(8 * k);
        assign ring_we[k] = wr && ((is_d && (req_offset == BASE || req_offset == BASE + 6'd4))
                                || (is_q && req_offset == BASE));
    end
    assign ring_mask  = is_q ? 2'b11 : (req_offset[2] ? 2'b10 : 2'b01);
    assign ring_wdata = is_q ? req_wdata : {req_wdata[31:0], req_wdata[31:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            cfgvec_q <= '0;
            qsel_q   <= '0;
        end else begin
            if (wr && is_b && req_offset == OFF_STATUS) status_q <= req_wdata[7:0];
            if (wr && is_w && req_offset == OFF_CFGVEC) cfgvec_q <= req_wdata[15:0];
            if (wr && is_w && req_offset == OFF_QSEL)   qsel_q   <= req_wdata[15:0];
        end
    end

    vq_feature_pager #(.SELW(32), .PAGES(2)) u_pager (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_dev_sel (wr && is_d && req_offset == OFF_DFSEL),
        .we_drv_sel (wr && is_d && req_offset == OFF_DRFSEL),
        .we_ack     (wr && is_d && req_offset == OFF_DRFEAT),
        .wdata      (req_wdata[31:0]),
        .features   (dev_features),
        .dev_sel    (dev_sel),
        .drv_sel    (drv_sel),
        .page_out   (feat_page),
        .ack_valid  (feat_ack_valid),
        .ack_data   (feat_ack_data)
    );

    vq_queue_bank #(.NQ(NQ), .QSIZE_MAX(QSIZE_MAX), .QIW(QIW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idx   (qsel_q[QIW-1:0]),
        .sel_ok    (sel_ok),
        .we_size   (wr && is_w && req_offset == OFF_QSIZE),
        .we_vec    (wr && is_w && req_offset == OFF_QVEC),
        .we_en     (wr && is_w && req_offset == OFF_QEN),
        .ring_we   (ring_we),
        .ring_mask (ring_mask),
        .wdata     (ring_wdata),
        .rd_size   (b_size),
        .rd_vec    (b_vec),
        .rd_en     (b_en),
        .q_size_o  (q_size),
        .q_en_o    (q_enable),
        .q_desc_o  (q_desc),
        .q_avail_o (q_avail),
        .q_used_o  (q_used)
    );

    // width-selective read decode
    always_comb begin
        rd_mux = '0;
        if (is_b) begin
            if (req_offset == OFF_STATUS) rd_mux = {56'h0, status_q};
        end else if (is_w) begin
            case (req_offset)
                OFF_CFGVEC:  rd_mux = {48'h0, cfgvec_q};
                OFF_NUMQ:    rd_mux = {48'h0, NQ_VAL};
                OFF_QSEL:    rd_mux = {48'h0, qsel_q};
                OFF_QSIZE:   rd_mux = {48'h0, b_size};
                OFF_QVEC:    rd_mux = {48'h0, b_vec};
                OFF_QEN:     rd_mux = {63'h0, b_en};
                OFF_QNOTIFY: rd_mux = {48'h0, qsel_q};
                default:     rd_mux = '0;
            endcase
        end else if (is_d) begin
            case (req_offset)
                OFF_DFSEL:  rd_mux = {32'h0, dev_sel};
                OFF_DFEAT:  rd_mux = {32'h0, feat_page};
                OFF_DRFSEL: rd_mux = {32'h0, drv_sel};
                default:    rd_mux = '0;
            endcase
        end
    end

    // response state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // response outputs
    always_ff @(posedge clk) begin
        if (!rst_n)  rsp_rdata <= '0;
        else if (rd) rsp_rdata <= rd_mux;
    end
    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/vq_common_regs_chk.sv
module vq_common_regs_chk #(
    parameter int NQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       req_size,
    input logic [5:0]       req_offset,
    input logic             rsp_valid,
    input logic [63:0]      rsp_rdata,
    input logic             feat_ack_valid,
    input logic [63:0]      feat_ack_data,
    input logic [NQ-1:0]    q_enable
);
    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);                                   // R2
    AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));                              // R2
    AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 3'd0) |=> (rsp_rdata[63:8] == 56'h0)); // R3
    AST_QWORD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 3'd3) |=> (rsp_rdata == 64'h0));   // R10
    AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size > 3'd3) |=> (rsp_rdata == 64'h0));    // R11
    AST_ACK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ack_valid |-> $past(req_valid && req_write && req_size == 3'd2 && req_offset == 6'h0C)); // R5
    AST_ACK_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ack_valid |-> (feat_ack_data[63:32] == 32'h0 || feat_ack_data[31:0] == 32'h0)); // R5
    AST_ENABLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_enable) |-> $past(req_valid && req_write && req_size == 3'd1 && req_offset == 6'h1C)); // R8
endmodule

bind vq_common_regs vq_common_regs_chk #(.NQ(NQ)) u_chk (.*);

// File: tb/vq_common_regs_tb_top.sv
`timescale 1ns/1ps
module vq_common_regs_tb_top;
    localparam int NQ = 3;
    localparam int QMAX = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_size = '0;
    logic [5:0]  req_offset = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, feat_ack_valid;
    logic [63:0] rsp_rdata, feat_ack_data;
    logic [63:0] dev_features = 64'h1234_5678_9ABC_DEF0;
    logic [NQ*16-1:0] q_size;
    logic [NQ-1:0]    q_enable;
    logic [NQ*64-1:0] q_desc, q_avail, q_used;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vq_common_regs #(.NQ(NQ), .QSIZE_MAX(QMAX)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sz, input logic [5:0] off, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = sz; req_offset = off; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [2:0] sz, input logic [5:0] off, input logic [63:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_size = sz; req_offset = off;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
        chk(rsp_rdata === exp, tag, rsp_rdata, exp);
    endtask

    task automatic t_reset;
        chk(rsp_valid === 1'b0 && rsp_rdata === 64'h0, "R1 rsp idle", rsp_rdata, 64'h0);
        chk(q_enable === '0 && q_desc === '0 && q_used === '0, "R1 queue outs", {61'h0, q_enable}, 64'h0);
        chk(q_size === {3{16'd256}}, "R1 q_size", {16'h0, q_size}, {16'h0, {3{16'd256}}});
        rd(3'd1, 6'h18, 64'd256, "R1 size read");
        rd(3'd0, 6'h14, 64'h0, "R1 status");
        rd(3'd2, 6'h00, 64'h0, "R1 dfsel");
    endtask

    task automatic t_status;
        wr(3'd0, 6'h14, 64'hFF);
        rd(3'd0, 6'h14, 64'hFF, "R6 status all bits");
        wr(3'd0, 6'h15, 64'hAA);
        rd(3'd0, 6'h15, 64'h0, "R6 generation read-only");
        rd(3'd1, 6'h14, 64'h0, "R3 word read at byte offset");
        wr(3'd1, 6'h14, 64'h0);
        rd(3'd0, 6'h14, 64'hFF, "R3 word write at byte offset ignored");
    endtask

    task automatic t_features;
        rd(3'd2, 6'h04, 64'h9ABC_DEF0, "R4 page0");
        wr(3'd2, 6'h00, 64'h1);
        rd(3'd2, 6'h04, 64'h1234_5678, "R4 page1");
        wr(3'd2, 6'h04, 64'h0);
        rd(3'd2, 6'h04, 64'h1234_5678, "R6 features read-only");
        wr(3'd2, 6'h00, 64'h2);
        rd(3'd2, 6'h04, 64'h0, "R4 page2 zero");
        rd(3'd2, 6'h00, 64'h2, "R4 select readback");
    endtask

    task automatic t_ack;
        wr(3'd2, 6'h08, 64'h1);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = 3'd2; req_offset = 6'h0C; req_wdata = 64'hA5A5_0001;
        @(negedge clk);
        req_valid = 0;
        chk(feat_ack_valid === 1'b1, "R5 ack pulse", {63'h0, feat_ack_valid}, 64'h1);
        chk(feat_ack_data === 64'hA5A5_0001_0000_0000, "R5 ack page1", feat_ack_data, 64'hA5A5_0001_0000_0000);
        @(negedge clk);
        chk(feat_ack_valid === 1'b0, "R5 ack one cycle", {63'h0, feat_ack_valid}, 64'h0);
        wr(3'd2, 6'h08, 64'h0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = 3'd2; req_offset = 6'h0C; req_wdata = 64'h0000_00C3;
        @(negedge clk);
        req_valid = 0;
        chk(feat_ack_valid === 1'b1 && feat_ack_data === 64'hC3, "R5 ack page0", feat_ack_data, 64'hC3);
        wr(3'd2, 6'h08, 64'h2);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = 3'd2; req_offset = 6'h0C; req_wdata = 64'hFFFF;
        @(negedge clk);
        req_valid = 0;
        chk(feat_ack_valid === 1'b0, "R5 ack dropped sel2", {63'h0, feat_ack_valid}, 64'h0);
        rd(3'd2, 6'h0C, 64'h0, "R11 dword read 0x0C");
    endtask

    task automatic t_queue_misc;
        rd(3'd1, 6'h12, 64'd3, "R7 num queues");
        wr(3'd1, 6'h12, 64'h9);
        rd(3'd1, 6'h12, 64'd3, "R6 num queues read-only");
        wr(3'd1, 6'h16, 64'h2);
        rd(3'd1, 6'h1E, 64'h2, "R7 notify offset");
        wr(3'd1, 6'h1E, 64'h7);
        rd(3'd1, 6'h16, 64'h2, "R6 notify write ignored");
        wr(3'd1, 6'h1A, 64'h0033);
        rd(3'd1, 6'h1A, 64'h0033, "R3 queue vector");
        wr(3'd1, 6'h18, 64'h0040);
        chk(q_size[2*16 +: 16] === 16'h40, "R3 queue size out", {48'h0, q_size[32 +: 16]}, 64'h40);
        wr(3'd1, 6'h10, 64'hBEEF);
        rd(3'd1, 6'h10, 64'hBEEF, "R3 config vector");
        rd(3'd0, 6'h16, 64'h0, "R11 byte read 0x16");
    endtask

    task automatic t_enable;
        wr(3'd1, 6'h16, 64'h1);
        wr(3'd1, 6'h1C, 64'h1);
        rd(3'd1, 6'h1C, 64'h1, "R8 enable set");
        chk(q_enable === 3'b010, "R8 enable out", {61'h0, q_enable}, 64'h2);
        wr(3'd1, 6'h1C, 64'h101);
        rd(3'd1, 6'h1C, 64'h0, "R8 non-one clears");
        wr(3'd1, 6'h1C, 64'h1);
        wr(3'd1, 6'h1C, 64'h2);
        chk(q_enable === 3'b000, "R8 value 2 clears", {61'h0, q_enable}, 64'h0);
    endtask

    task automatic t_rings;
        wr(3'd1, 6'h16, 64'h1);
        wr(3'd2, 6'h20, 64'h1111_2222);
        wr(3'd2, 6'h24, 64'h3333_4444);
        chk(q_desc[64 +: 64] === 64'h3333_4444_1111_2222, "R9 desc halves", q_desc[64 +: 64], 64'h3333_4444_1111_2222);
        wr(3'd3, 6'h28, 64'hAAAA_BBBB_CCCC_DDDD);
        chk(q_avail[64 +: 64] === 64'hAAAA_BBBB_CCCC_DDDD, "R9 avail qword", q_avail[64 +: 64], 64'hAAAA_BBBB_CCCC_DDDD);
        wr(3'd0, 6'h16, 64'h0);
        wr(3'd3, 6'h30, 64'h0102_0304_0506_0708);
        wr(3'd2, 6'h34, 64'h9999_0000);
        chk(q_used[64 +: 64] === 64'h9999_0000_0506_0708, "R9 used qword then hi", q_used[64 +: 64], 64'h9999_0000_0506_0708);
        chk(q_used[0 +: 64] === 64'h0 && q_used[128 +: 64] === 64'h0, "R9 other queues", q_used[0 +: 64], 64'h0);
        rd(3'd2, 6'h20, 64'h0, "R9 dword ring read zero");
        rd(3'd3, 6'h28, 64'h0, "R10 qword read");
        rd(3'd3, 6'h00, 64'h0, "R10 qword read 0x00");
        wr(3'd3, 6'h24, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(q_desc[64 +: 64] === 64'h3333_4444_1111_2222, "R11 misplaced qword ignored", q_desc[64 +: 64], 64'h3333_4444_1111_2222);
    endtask

    task automatic t_bad_size;
        rd(3'd5, 6'h14, 64'h0, "R11 size code 5 read");
        wr(3'd4, 6'h14, 64'h11);
        rd(3'd0, 6'h14, 64'hFF, "R11 size code 4 write ignored");
        rd(3'd1, 6'h22, 64'h0, "R11 undefined word offset");
    endtask

    task automatic t_out_of_range;
        logic [NQ*16-1:0] sz0;
        logic [NQ*64-1:0] d0;
        sz0 = q_size; d0 = q_desc;
        wr(3'd1, 6'h16, 64'h3);
        wr(3'd1, 6'h18, 64'h10);
        wr(3'd1, 6'h1C, 64'h1);
        wr(3'd3, 6'h20, 64'h5555_5555_5555_5555);
        rd(3'd1, 6'h18, 64'h0, "R12 size read zero");
        rd(3'd1, 6'h1C, 64'h0, "R12 enable read zero");
        chk(q_size === sz0, "R12 size writes discarded", {16'h0, q_size}, {16'h0, sz0});
        chk(q_desc === d0 && q_enable === '0, "R12 ring/enable discarded", {61'h0, q_enable}, 64'h0);
        wr(3'd1, 6'h16, 64'h2);
        rd(3'd1, 6'h18, 64'h40, "R12 in-range neighbour intact");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_status();
        t_features();
        t_ack();
        t_queue_misc();
        t_enable();
        t_rings();
        t_bad_size();
        t_out_of_range();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule